// File: doc/BRIEF.md
# Digital Video Byte-Stream Deframer

This block sits right after an external video decoder. It takes the decoder's byte-wide component stream one byte per clock. It searches the stream for the embedded timing references that mark the start and end of active picture on each line. From the status byte of each reference it keeps three flags: the current field, whether the line lies in vertical blanking, and whether the stream is in horizontal blanking.

Between a start-of-active reference on a visible line and the next end-of-active reference, the block groups the 4:2:2 samples into words of four bytes. The chroma-blue / luma / chroma-red / luma order of the stream is kept, so each output word holds one pixel pair. A single-cycle strobe marks each word. Downstream logic, such as an effects stage or a clock-crossing buffer, uses the strobe as a write enable. It uses the field and vertical-blank flags to find frame boundaries.

After reset the block treats the stream as blanking. It emits nothing until it has seen a valid timing reference.

Top module: `vid_stream_parser`

## Requirements
- R1: While reset is held and after it is released, `pix_valid` is 0, `field_id` is 0, and `vblank` and `hblank` are both 1.
- R2: A timing reference is four consecutive bytes: all ones (0xFF), all zeros, all zeros, then a status byte whose bit 7 is 1. Status bit 6 is the field, bit 5 is vertical blanking, and bit 4 is 1 for end-of-active and 0 for start-of-active. `field_id`, `vblank` and `hblank` take bits 6, 5 and 4 in the cycle after the status byte is sampled.
- R3: A status byte whose bit 7 is 0 is not a reference. It leaves the three flags unchanged and opens no video window.
- R4: Inside an open video window, every group of four bytes gives one word. The first byte goes to bits 31:24, the second to 23:16, the third to 15:8 and the fourth to 7:0. `pix_valid` is high for exactly one cycle, in the cycle after the fourth byte is sampled.
- R5: After a start-of-active reference with vertical-blank bit 1, no word is produced.
- R6: Bytes between an end-of-active reference and the next start-of-active reference produce no word.
- R7: Bytes that arrive before the first valid reference after reset produce no word.
- R8: A 0xFF byte inside an open window closes the window at once. An incomplete group pending at that point is dropped, and no later byte produces a word until the next start-of-active reference.
- R9: Grouping restarts at every start-of-active reference. The first byte after it always lands in bits 31:24, whatever was left incomplete on the previous line.
- R10: An all-ones byte followed by a byte other than all zeros in the second or third position is not a reference. The flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder byte clock; all logic on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vid_byte | input | 8 | Incoming stream byte, one per clock |
| pix_word | output | 32 | Packed pixel pair, first byte in the top lane |
| pix_valid | output | 1 | One-cycle strobe for a new `pix_word` |
| field_id | output | 1 | Field bit of the latest valid reference |
| vblank | output | 1 | Vertical-blank bit of the latest valid reference |
| hblank | output | 1 | High from end-of-active until the next start-of-active |

## Verification
The bench builds the block with its defaults: 8-bit bytes, four lanes per word, and the first byte in the most significant lane. This is exactly the pixel-pair layout that the lane-placement rule of R4 and the realignment rule of R9 describe. With four lanes, a line cut short after six bytes leaves a two-byte remnant. That remnant exercises the drop on close and the restart on the next line. With 8-bit bytes, the reference preamble is the literal 0xFF/0x00 pattern, so the broken preambles and the cleared status-marker bit can be written as plain byte values.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

   // progress through the three-byte preamble that precedes a status byte
   typedef enum logic [1:0] {
      PRE_NONE  = 2'd0,
      PRE_ONES  = 2'd1,
      PRE_ZERO1 = 2'd2,
      PRE_ZERO2 = 2'd3
   } pre_state_t;

   // status flags carried by the last accepted reference
   typedef struct packed {
      logic fld;
      logic vbl;
      logic hbl;
   } trc_flags_t;

   function automatic pre_state_t pre_next(pre_state_t cur, logic is_ones, logic is_zero);
      pre_state_t nxt;
      if (is_ones)
         nxt = PRE_ONES;
      else begin
         unique case (cur)
            PRE_ONES:  nxt = is_zero ? PRE_ZERO1 : PRE_NONE;
            PRE_ZERO1: nxt = is_zero ? PRE_ZERO2 : PRE_NONE;
            default:   nxt = PRE_NONE;
         endcase
      end
      return nxt;
   endfunction

endpackage

// File: rtl/vsp_trc_detect.sv
module vsp_trc_detect
   import vsp_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] din,
   output trc_flags_t        flags,
   output logic              win_open,
   output logic              win_close
);

   localparam int MARK_BIT = BYTE_W - 1;
   localparam int FLD_BIT  = BYTE_W - 2;
   localparam int VBL_BIT  = BYTE_W - 3;
   localparam int HBL_BIT  = BYTE_W - 4;

   pre_state_t st;
   logic       is_ones, is_zero, status_hit;

   assign is_ones    = (din == {BYTE_W{1'b1}});
   assign is_zero    = (din == {BYTE_W{1'b0}});
   assign status_hit = (st == PRE_ZERO2) && din[MARK_BIT];
   assign win_close  = win_open && is_ones;

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= PRE_NONE;
         flags    <= '{fld: 1'b0, vbl: 1'b1, hbl: 1'b1};
         win_open <= 1'b0;
      end else begin
         st <= pre_next(st, is_ones, is_zero);
         if (status_hit) begin
            flags.fld <= din[FLD_BIT];
            flags.vbl <= din[VBL_BIT];
            flags.hbl <= din[HBL_BIT];
            win_open  <= !din[HBL_BIT] && !din[VBL_BIT];
         end else if (win_close) begin
            win_open  <= 1'b0;
         end
      end
   end

   // R2: flags change only right after a full preamble
   a_r2_flags_need_preamble: assert property (@(posedge clk) disable iff (rst)
      !$stable(flags) |-> $past(st == PRE_ZERO2));

   // R3: status byte lacking its marker bit leaves flags alone
   a_r3_unmarked_ignored: assert property (@(posedge clk) disable iff (rst)
      (st == PRE_ZERO2 && !din[MARK_BIT]) |=> $stable(flags) && !$rose(win_open));

   // R8: an all-ones byte inside the window shuts it
   a_r8_ones_closes: assert property (@(posedge clk) disable iff (rst)
      (win_open && is_ones) |=> !win_open);

endmodule

// File: rtl/vsp_packer.sv
module vsp_packer #(
   parameter int BYTE_W    = 8,
   parameter int LANES     = 4,
   parameter bit FIRST_MSB = 1'b1,
   localparam int WORD_W   = BYTE_W * LANES,
   localparam int LANE_W   = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic              flush,
   input  logic [BYTE_W-1:0] din,
   output logic [WORD_W-1:0] word,
   output logic              word_vld
);

   logic [LANE_W-1:0] lane;
   logic [BYTE_W-1:0] hold [LANES-1];
   logic [WORD_W-1:0] assembled;
   logic              last;

   assign last = (lane == LANE_W'(LANES - 1));

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      logic [BYTE_W-1:0] b;
      if (gi == LANES - 1) begin : g_cur
         assign b = din;
      end else begin : g_held
         assign b = hold[gi];
      end
      if (FIRST_MSB) begin : g_msb
         assign assembled[(LANES-1-gi)*BYTE_W +: BYTE_W] = b;
      end else begin : g_lsb
         assign assembled[gi*BYTE_W +: BYTE_W] = b;
      end
   end

   always_ff @(posedge clk) begin
      if (take && !last)
         hold[lane[LANE_W-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lane     <= '0;
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (flush) begin
            lane <= '0;
         end else if (take) begin
            if (last) begin
               word     <= assembled;
               word_vld <= 1'b1;
               lane     <= '0;
            end else begin
               lane <= lane + 1'b1;
            end
         end
      end
   end

   // R4: strobe lasts one cycle and follows an accepted byte
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
      word_vld |=> !word_vld);
   a_r4_strobe_after_take: assert property (@(posedge clk) disable iff (rst)
      word_vld |-> $past(take));

   // R9: a flush never yields a word in the next cycle
   a_r9_flush_no_word: assert property (@(posedge clk) disable iff (rst)
      flush |=> !word_vld);

endmodule

// File: rtl/vid_stream_parser.sv
module vid_stream_parser
   import vsp_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int LANES     = 4,
   parameter bit FIRST_MSB = 1'b1,
   localparam int WORD_W   = BYTE_W * LANES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] vid_byte,
   output logic [WORD_W-1:0] pix_word,
   output logic              pix_valid,
   output logic              field_id,
   output logic              vblank,
   output logic              hblank
);

   if (BYTE_W < 8) begin : g_chk_byte
      $error("BYTE_W must be at least 8 to hold the status flags");
   end
   if (LANES < 2 || (LANES % 2) != 0) begin : g_chk_lanes
      $error("LANES must be an even number of at least 2");
   end

   trc_flags_t flags;
   logic       win_open, win_close, take, flush;

   vsp_trc_detect #(.BYTE_W(BYTE_W)) u_detect (
      .clk       (clk),
      .rst       (rst),
      .din       (vid_byte),
      .flags     (flags),
      .win_open  (win_open),
      .win_close (win_close)
   );

   assign take  = win_open && !win_close;
   assign flush = !take;

   vsp_packer #(.BYTE_W(BYTE_W), .LANES(LANES), .FIRST_MSB(FIRST_MSB)) u_pack (
      .clk      (clk),
      .rst      (rst),
      .take     (take),
      .flush    (flush),
      .din      (vid_byte),
      .word     (pix_word),
      .word_vld (pix_valid)
   );

   assign field_id = flags.fld;
   assign vblank   = flags.vbl;
   assign hblank   = flags.hbl;

   // R5 and R6: words appear only on visible, active lines
   a_r5_no_word_vblank: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> !vblank);
   a_r6_no_word_hblank: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> !hblank);

   // R1: reset state checked at every edge in reset
   always_ff @(posedge clk) begin
      if (rst) begin
         a_r1_reset_idle: assert (!pix_valid || $isunknown(pix_valid));
      end
   end

endmodule

// File: tb/sim_vid_stream_parser.sv
module sim_vid_stream_parser;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  vid_byte = 8'h10;
   logic [31:0] pix_word;
   logic        pix_valid, field_id, vblank, hblank;

   int          checks = 0;
   int          fails = 0;
   int          words_seen = 0;
   string       cur_req = "R7";
   logic [31:0] exp_q [$];
   logic [31:0] mon_exp;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   vid_stream_parser u0 (
      .clk(clk), .rst(rst), .vid_byte(vid_byte),
      .pix_word(pix_word), .pix_valid(pix_valid),
      .field_id(field_id), .vblank(vblank), .hblank(hblank)
   );

   // monitor: scoreboard comparison
   always @(negedge clk) begin
      if (!rst && pix_valid) begin
         words_seen++;
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected word %h, expected none", cur_req, pix_word);
         end else begin
            mon_exp = exp_q.pop_front();
            if (pix_word !== mon_exp) begin
               fails++;
               $display("FAIL %s: word %h, expected %h", cur_req, pix_word, mon_exp);
            end
         end
      end
   end

   function automatic logic [7:0] sample_byte(int k);
      return 8'h10 + 8'((k * 37) % 224);
   endfunction

   task automatic send_byte(logic [7:0] b);
      @(negedge clk);
      vid_byte = b;
   endtask

   task automatic send_trc(logic [7:0] xy);
      send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(xy);
   endtask

   task automatic send_words(int n, int seed);
      for (int w = 0; w < n; w++) begin
         logic [7:0] b0, b1, b2, b3;
         b0 = sample_byte(seed + 4*w);
         b1 = sample_byte(seed + 4*w + 1);
         b2 = sample_byte(seed + 4*w + 2);
         b3 = sample_byte(seed + 4*w + 3);
         exp_q.push_back({b0, b1, b2, b3});
         send_byte(b0); send_byte(b1); send_byte(b2); send_byte(b3);
      end
   endtask

   task automatic send_raw(int n, int seed);
      for (int i = 0; i < n; i++) send_byte(sample_byte(seed + i));
   endtask

   task automatic check_status(logic f, logic v, logic h, string req);
      @(posedge clk); #1;
      checks++;
      if ({field_id, vblank, hblank} !== {f, v, h}) begin
         fails++;
         $display("FAIL %s: f/v/h %b%b%b, expected %b%b%b", req,
                  field_id, vblank, hblank, f, v, h);
      end
   endtask

   task automatic check_count(int base, int delta, string req);
      repeat (2) @(negedge clk);
      checks++;
      if (words_seen - base != delta) begin
         fails++;
         $display("FAIL %s: words %0d, expected %0d", req, words_seen - base, delta);
      end
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if ({pix_valid, field_id, vblank, hblank} !== 4'b0011) begin
         fails++;
         $display("FAIL R1: v/f/vb/hb %b, expected 0011",
                  {pix_valid, field_id, vblank, hblank});
      end
      rst = 1'b0;
      check_status(1'b0, 1'b1, 1'b1, "R1");

      // R7: data before any reference
      cur_req = "R7"; base = words_seen;
      send_raw(20, 3);
      check_count(base, 0, "R7");

      // R2 and R5: vertical blanking line
      cur_req = "R5"; base = words_seen;
      send_trc(8'hB0); check_status(1'b0, 1'b1, 1'b1, "R2");
      send_raw(8, 50);
      send_trc(8'hA0); check_status(1'b0, 1'b1, 1'b0, "R2");
      send_raw(12, 70);
      send_trc(8'hB0);
      check_count(base, 0, "R5");

      // R4 and R6: visible line, then horizontal blanking
      cur_req = "R4"; base = words_seen;
      send_trc(8'h80); check_status(1'b0, 1'b0, 1'b0, "R2");
      send_words(3, 100);
      send_trc(8'h90); check_status(1'b0, 1'b0, 1'b1, "R2");
      cur_req = "R6";
      send_raw(9, 130);
      check_count(base, 3, "R6");

      // R3: status byte without marker bit
      cur_req = "R3"; base = words_seen;
      send_trc(8'h40); check_status(1'b0, 1'b0, 1'b1, "R3");
      send_raw(8, 200);
      check_count(base, 0, "R3");

      // R10: broken preamble
      cur_req = "R10"; base = words_seen;
      send_byte(8'hFF); send_byte(8'h00); send_byte(8'h55); send_byte(8'h80);
      check_status(1'b0, 1'b0, 1'b1, "R10");
      send_raw(8, 220);
      check_count(base, 0, "R10");

      // R8 and R9: short line leaves a remnant, next line realigns
      cur_req = "R9"; base = words_seen;
      send_trc(8'hC0); check_status(1'b1, 1'b0, 1'b0, "R2");
      send_words(1, 300);
      send_raw(2, 310);
      send_trc(8'hD0); check_status(1'b1, 1'b0, 1'b1, "R2");
      send_trc(8'hC0);
      send_words(2, 400);
      send_trc(8'hD0);
      check_count(base, 3, "R9");

      // R8: lone all-ones byte mid-word closes the window
      cur_req = "R8"; base = words_seen;
      send_trc(8'hC0);
      send_words(1, 500);
      send_raw(3, 510);
      send_byte(8'hFF); send_byte(8'h10); send_byte(8'h20);
      send_raw(4, 520);
      send_trc(8'hD0);
      check_count(base, 1, "R8");

      // R4: every expected word consumed
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R4: %0d words pending, expected 0", exp_q.size());
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run still busy, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule